// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop period. The line idles high. A set of line-control inputs chooses the character size, the parity mode (even, odd or a fixed "stick" value) and the stop length. A break input holds the line low for as long as it is set.

The bit rate comes from a 16-bit divisor. A tick is produced every `divisor` clock cycles, with a divisor of 0 taken as 1, and every bit lasts 16 ticks. Bytes arrive over a valid/ready handshake into a one-byte holding stage. From there they move into the shifter as soon as the shifter is idle. Two status outputs report an empty holding stage and a fully idle transmitter.

The character settings are captured when a byte moves into the shifter, so each frame is internally consistent. The break control acts on the line at once.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1 and `hold_empty`, `tx_empty` and `in_ready` are all 1.
- R2: A frame is a 0 start bit followed by the data bits, least significant first. The number of data bits is set by `lc_wlen`: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused upper data bits are not sent.
- R3: Every start, data and parity bit lasts 16×D clock cycles, where D is `divisor`, or 1 when `divisor` is 0.
- R4: When `lc_par_en` is 1 and `lc_par_stick` is 0, a parity bit follows the data bits. With `lc_par_even`=1 the data bits plus the parity bit hold an even number of ones. With `lc_par_even`=0 they hold an odd number.
- R5: When `lc_par_en` and `lc_par_stick` are both 1, the parity bit is 0 if `lc_par_even` is 1 and 1 if `lc_par_even` is 0.
- R6: The stop period is high. It lasts 16 ticks when `lc_stop2` is 0. When `lc_stop2` is 1 it lasts 24 ticks for 5-bit characters and 32 ticks otherwise.
- R7: While `lc_brk` is 1, `txd` is 0 from the next cycle on. Frame sequencing and timing are unaffected, and the line shows the normal frame level again once `lc_brk` returns to 0.
- R8: `in_ready` equals `hold_empty`. A transfer with `in_valid` and `in_ready` both high clears `hold_empty` on the next cycle. `hold_empty` sets again when the byte moves into an idle shifter.
- R9: `tx_empty` is 1 only when the holding stage is empty and no frame is in progress. It rises when the stop period of the last frame ends.
- R10: `lc_wlen`, `lc_stop2`, `lc_par_en`, `lc_par_even` and `lc_par_stick` are sampled when a byte enters the shifter. Changes to them during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Holding stage can accept a byte |
| lc_wlen | input | 2 | Character size code (00=5 … 11=8 bits) |
| lc_stop2 | input | 1 | Long stop period select |
| lc_par_en | input | 1 | Parity bit enable |
| lc_par_even | input | 1 | Even parity select (stick value select in stick mode) |
| lc_par_stick | input | 1 | Fixed-value parity |
| lc_brk | input | 1 | Force line low |
| divisor | input | 16 | Clock cycles per oversampling tick |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shifter both idle |

## Verification
Several properties are checked by the assertions on every cycle. The break override drives the line low one cycle after `lc_brk`. The handshake empties and fills the holding stage correctly. `tx_empty` never shows while a byte is still held. An idle transmitter keeps the line high. Frame content and timing can only be shown by the bench's scenarios, which sample each bit in mid-period and compare the frame length with the configured divisor. These include the data order and count for each size code, the even, odd and stick parity values, the 1, 1.5 and 2 bit stop lengths, the divisor-of-zero case, and the capture of the settings at frame start.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // Parity value for a character of (wlen+5) bits.
  function automatic logic parity_of(input logic [7:0] data,
                                     input logic [1:0] wlen,
                                     input logic       even,
                                     input logic       stick);
    logic [7:0] mask;
    logic       ones_odd;
    mask     = 8'hFF >> (2'd3 - wlen);
    ones_odd = ^(data & mask);
    if (stick) begin
      parity_of = ~even;
    end else if (even) begin
      parity_of = ones_odd;
    end else begin
      parity_of = ~ones_odd;
    end
  endfunction

endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    tick    = (cnt_q >= div_eff - DIV_W'(1));
    if (clr || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              accept;
  logic              data_en;

  always_comb begin
    in_ready = ~hold_full;
    accept   = in_valid & in_ready;
    data_en  = accept;
    data_d   = in_data;
    full_d   = hold_full;
    if (take) begin
      full_d = 1'b0;
    end else if (accept) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      hold_full <= full_d;
      if (data_en) begin
        hold_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  output logic              take,
  output logic              busy,
  output logic              ser_bit
);
  localparam int TCNT_W = $clog2(2 * OVS);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] LIM_ONE  = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] LIM_HALF = TCNT_W'(OVS + OVS / 2 - 1);
  localparam logic [TCNT_W-1:0] LIM_TWO  = TCNT_W'(2 * OVS - 1);
  localparam logic [BIDX_W-1:0] MIN_LAST = BIDX_W'(4);

  tx_state_e         state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [1:0]        wlen_q, wlen_d;
  logic              stop2_q, stop2_d;
  logic              pen_q, pen_d;
  logic              par_q, par_d;
  logic [TCNT_W-1:0] limit;
  logic              bit_done;
  logic [BIDX_W-1:0] last_idx;

  always_comb begin
    take     = (state_q == ST_IDLE) && hold_full;
    busy     = (state_q != ST_IDLE);
    last_idx = BIDX_W'(wlen_q) + MIN_LAST;

    if (state_q == ST_STOP && stop2_q) begin
      limit = (wlen_q == 2'b00) ? LIM_HALF : LIM_TWO;
    end else begin
      limit = LIM_ONE;
    end
    bit_done = tick && (tcnt_q == limit);

    unique case (state_q)
      ST_START:  ser_bit = 1'b0;
      ST_DATA:   ser_bit = sreg_q[0];
      ST_PARITY: ser_bit = par_q;
      default:   ser_bit = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    bidx_d  = bidx_q;
    sreg_d  = sreg_q;
    wlen_d  = wlen_q;
    stop2_d = stop2_q;
    pen_d   = pen_q;
    par_d   = par_q;
    if (bit_done) begin
      tcnt_d = '0;
    end else if (tick) begin
      tcnt_d = tcnt_q + TCNT_W'(1);
    end else begin
      tcnt_d = tcnt_q;
    end

    unique case (state_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (take) begin
          state_d = ST_START;
          bidx_d  = '0;
          sreg_d  = hold_data;
          wlen_d  = cfg_wlen;
          stop2_d = cfg_stop2;
          pen_d   = cfg_par_en;
          par_d   = parity_of(hold_data, cfg_wlen, cfg_par_even, cfg_par_stick);
        end
      end
      ST_START: begin
        if (bit_done) begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          if (bidx_q == last_idx) begin
            state_d = pen_q ? ST_PARITY : ST_STOP;
          end else begin
            bidx_d = bidx_q + BIDX_W'(1);
            sreg_d = sreg_q >> 1;
          end
        end
      end
      ST_PARITY: begin
        if (bit_done) begin
          state_d = ST_STOP;
        end
      end
      default: begin
        if (bit_done) begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      sreg_q  <= '0;
      wlen_q  <= 2'b11;
      stop2_q <= 1'b0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      sreg_q  <= sreg_d;
      wlen_q  <= wlen_d;
      stop2_q <= stop2_d;
      pen_q   <= pen_d;
      par_q   <= par_d;
    end
  end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_bit,
  input  logic brk,
  output logic txd
);
  logic txd_d;

  always_comb begin
    txd_d = brk ? 1'b0 : ser_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd <= 1'b1;
    end else begin
      txd <= txd_d;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        lc_wlen,
  input  logic              lc_stop2,
  input  logic              lc_par_en,
  input  logic              lc_par_even,
  input  logic              lc_par_stick,
  input  logic              lc_brk,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  logic              rst_n_sync;
  logic              tick;
  logic              take;
  logic              busy;
  logic              ser_bit;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  uart_tx_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  uart_tx_tick #(.DIV_W(DIV_W)) i_tick (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .clr     (take),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  uart_tx_seq #(.DATA_W(DATA_W), .OVS(OVS)) i_seq (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .tick          (tick),
    .hold_full     (hold_full),
    .hold_data     (hold_data),
    .cfg_wlen      (lc_wlen),
    .cfg_stop2     (lc_stop2),
    .cfg_par_en    (lc_par_en),
    .cfg_par_even  (lc_par_even),
    .cfg_par_stick (lc_par_stick),
    .take          (take),
    .busy          (busy),
    .ser_bit       (ser_bit)
  );

  uart_tx_line i_line (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .ser_bit (ser_bit),
    .brk     (lc_brk),
    .txd     (txd)
  );

  assign hold_empty = ~hold_full;
  assign tx_empty   = ~hold_full & ~busy;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic lc_brk,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty
);
  // R7
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_brk |=> !txd);

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !hold_empty);

  // R8
  fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(in_valid && in_ready));

  // R8
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == hold_empty);

  // R9
  empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !lc_brk) |=> txd);
endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lc_brk     (lc_brk),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
  logic        clk;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  lc_wlen;
  logic        lc_stop2;
  logic        lc_par_en;
  logic        lc_par_even;
  logic        lc_par_stick;
  logic        lc_brk;
  logic [15:0] divisor;
  logic        txd;
  logic        hold_empty;
  logic        tx_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  uart_frame_tx i_uart_frame_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .lc_wlen      (lc_wlen),
    .lc_stop2     (lc_stop2),
    .lc_par_en    (lc_par_en),
    .lc_par_even  (lc_par_even),
    .lc_par_stick (lc_par_stick),
    .lc_brk       (lc_brk),
    .divisor      (divisor),
    .txd          (txd),
    .hold_empty   (hold_empty),
    .tx_empty     (tx_empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // mode 0: plain, 1: change size mid-frame (R10), 2: break pulse over data bit 3 (R7)
  task automatic run_frame(input string req, input logic [7:0] d, input logic [1:0] wl,
                           input logic s2, input logic pe, input logic ev,
                           input logic st, input logic [15:0] dv, input int mode);
    int nb, len, b, de, stop_t, n, exp_n;
    logic [11:0] expv, got;
    logic par;
    nb = 5 + int'(wl);
    de = (dv == 0) ? 1 : int'(dv);
    b  = 16 * de;
    expv = '1;
    expv[0] = 1'b0;
    for (int i = 0; i < nb; i++) expv[1+i] = d[i];
    par = st ? ~ev : (ev ? ^(d & (8'hFF >> (3 - wl))) : ~^(d & (8'hFF >> (3 - wl))));
    if (pe) expv[1+nb] = par;
    len = 2 + nb + (pe ? 1 : 0);
    stop_t = !s2 ? 16 : ((wl == 2'b00) ? 24 : 32);
    if (mode == 2) expv[3] = 1'b0;
    lc_wlen = wl; lc_stop2 = s2; lc_par_en = pe; lc_par_even = ev;
    lc_par_stick = st; divisor = dv;
    send_byte(d);
    n = 0;
    while (txd && n < 4000) begin @(negedge clk); n++; end
    n = 0;
    got = '1;
    for (int i = 0; i < len; i++) begin
      repeat ((i == 0) ? b / 2 : b) begin @(negedge clk); n++; end
      got[i] = txd;
      if (mode == 1 && i == 0) lc_wlen = 2'b00;
      if (mode == 2 && i == 2) lc_brk = 1'b1;
      if (mode == 2 && i == 3) lc_brk = 1'b0;
    end
    check({req, " frame bits"}, int'(got), int'(expv));
    while (!tx_empty && n < 20000) begin @(negedge clk); n++; end
    exp_n = (len - 1) * b + stop_t * de - 1;
    n_checks++;
    if (n < exp_n - 1 || n > exp_n + 1) begin
      n_fail++;
      $display("FAIL %s frame length: actual %0d expected %0d", req, n, exp_n);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 hold_empty", hold_empty, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic test_idle_break();
    @(negedge clk);
    lc_brk = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 idle break low", txd, 0);
    check("R7 break leaves tx_empty", tx_empty, 1);
    lc_brk = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 idle after break", txd, 1);
  endtask

  task automatic test_back_to_back();
    lc_wlen = 2'b11; lc_stop2 = 1'b0; lc_par_en = 1'b0; lc_par_even = 1'b0;
    lc_par_stick = 1'b0; divisor = 16'd1;
    @(negedge clk);
    in_data = 8'h3C; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 accept clears hold_empty", hold_empty, 0);
    check("R8 in_ready follows", in_ready, 0);
    @(negedge clk);
    check("R8 moved to shifter", hold_empty, 1);
    check("R9 busy shifter", tx_empty, 0);
    send_byte(8'hC3);
    check("R8 second byte held", hold_empty, 0);
    repeat (64) @(negedge clk);
    check("R8 held while first frame runs", hold_empty, 0);
    check("R9 not empty while held", tx_empty, 0);
    for (int k = 0; k < 1000 && !tx_empty; k++) @(negedge clk);
    check("R9 empty after both frames", tx_empty, 1);
    check("R9 line idle high", txd, 1);
  endtask

  initial begin
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; lc_wlen = 2'b11; lc_stop2 = 1'b0;
    lc_par_en = 1'b0; lc_par_even = 1'b0; lc_par_stick = 1'b0; lc_brk = 1'b0;
    divisor = 16'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    run_frame("R2 R3 R6 8N1", 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1, 0);
    run_frame("R2 R6 5-bit 1.5 stop", 8'hF3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 16'd2, 0);
    run_frame("R4 R6 6-bit even 2 stop", 8'h2D, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1, 0);
    run_frame("R4 R3 7-bit odd div3", 8'h5B, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 16'd3, 0);
    run_frame("R5 stick even", 8'hFF, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 16'd1, 0);
    run_frame("R5 stick odd", 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 16'd1, 0);
    run_frame("R3 divisor zero", 8'h96, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 0);
    run_frame("R10 size change mid-frame", 8'hE1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 1);
    run_frame("R7 break over data bit", 8'hFF, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2, 2);
    test_idle_break();
    test_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule